// File: doc/BRIEF.md
# Watchdog Timer with Programmable Postscaler

This block is a watchdog that counts ticks from a slow internal oscillator. A fixed divide-by-128 prescaler turns these ticks into a base period of about 4 ms. A 16-bit postscaler then stretches that base by a power of two, from 1:1 up to 1:32,768. The ratio is chosen by a 4-bit select field. The resulting timeout runs from roughly 4 ms to roughly 131 s. All logic runs on the system clock `clk`. `osc_tick` is a one-cycle strobe that marks each oscillator period.

Software keeps the watchdog quiet by pulsing `clr_pulse`. Entering sleep, changing the oscillator frequency-select value, or a reported clock failure also restarts the count. The watchdog is forced on by the configuration enable. When the configuration enable is off, the software enable turns it on instead. While the watchdog runs, the block asks its oscillator to stay on. When the count expires, the block raises a one-cycle wake-up request if the device is asleep, and a one-cycle reset request otherwise. The count then starts again from zero.

Top module: `wdt_top`

## Requirements
- R1: A synchronous active-high `rst` clears both counters. On the cycle after any reset cycle, `clk_src_en`, `rst_req` and `wake_req` are all low.
- R2: With `post_sel` = 0 and the watchdog enabled, the 128th `osc_tick` after a clear is a timeout. The request output is high on the clock cycle after that tick.
- R3: Select value s (0..15) sets the timeout to 128·2^s ticks. If s is lowered while a count is in progress, the timeout fires at the next 128-tick boundary at which the number of elapsed base periods is at least 2^s.
- R4: A `clr_pulse` or `sleep_enter` high in a cycle clears both counters in that cycle, and no timeout occurs in that cycle.
- R5: When `fsel` differs from its value on the previous clock cycle, both counters clear in that cycle.
- R6: `clk_fail` high in a cycle clears both counters in that cycle.
- R7: The watchdog is enabled when `cfg_en` is 1, whatever `sw_en` is. When `cfg_en` is 0, `sw_en` alone decides.
- R8: While the watchdog is disabled, both counters are held at zero and both request outputs stay low.
- R9: `clk_src_en` equals the enable state of the previous clock cycle.
- R10: A timeout in a cycle with `sleeping` = 1 gives a one-cycle `wake_req` and no `rst_req`.
- R11: A timeout in a cycle with `sleeping` = 0 gives a one-cycle `rst_req` and no `wake_req`. The counters restart from zero, so the next timeout needs a full period again.
- R12: The counters advance only in cycles with `osc_tick` = 1. Cycles without a tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| cfg_en | input | 1 | Configuration enable, forces the watchdog on |
| sw_en | input | 1 | Software enable, used only when `cfg_en` is 0 |
| post_sel | input | 4 | Postscaler ratio select, ratio 2^post_sel |
| clr_pulse | input | 1 | Clear-watchdog pulse |
| sleep_enter | input | 1 | Sleep-entry pulse, clears the count |
| fsel | input | 3 | Oscillator frequency-select value; a change clears the count |
| clk_fail | input | 1 | Clock-failure flag, clears the count |
| sleeping | input | 1 | Device is in sleep |
| clk_src_en | output | 1 | Keeps the oscillator clock source running |
| rst_req | output | 1 | One-cycle reset request on timeout while awake |
| wake_req | output | 1 | One-cycle wake-up request on timeout while asleep |

## Verification
The hardest case to reach from the ports is a timeout that lands on the same cycle as a clear event, or on a cycle in which the select field has just dropped below the elapsed count. Both need about 128 or more aligned ticks with no stray clear in between. The stimulus therefore uses directed runs with a tick every cycle and small select values. It places each clear source at a fixed cycle, just before a base boundary and away from one. A long random phase follows, with sparse ticks and rare clears, sleep toggles, select changes and resets. This drives the count through many boundaries while the conditions shift around it. A bench model holds one total tick count and predicts every output on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // sources that restart the watchdog count
  typedef struct packed {
    logic disabled;
    logic clr;
    logic sleep_in;
    logic fsel_chg;
    logic clk_bad;
  } wdt_clr_src_t;

  function automatic logic any_clear(input wdt_clr_src_t s);
    return s.disabled | s.clr | s.sleep_in | s.fsel_chg | s.clk_bad;
  endfunction
endpackage

// File: rtl/wdt_enable_ctl.sv
module wdt_enable_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cfg_en,
  input  logic sw_en,
  output logic run,
  output logic clk_src_en
);
  // configuration enable dominates; software bit matters only when it is off
  always_comb run = cfg_en ? 1'b1 : sw_en;

  always_ff @(posedge clk) begin
    if (rst) clk_src_en <= 1'b0;
    else     clk_src_en <= run;
  end
endmodule

// File: rtl/wdt_clear_gen.sv
module wdt_clear_gen #(
  parameter int FSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clr_pulse,
  input  logic              sleep_enter,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              clk_fail,
  output logic              clear
);
  import wdt_pkg::*;

  logic [FSEL_W-1:0] fsel_q;
  wdt_clr_src_t      src;

  // previous-cycle copy of the frequency select, captured during reset too
  always_ff @(posedge clk) fsel_q <= fsel;

  always_comb begin
    src.disabled = ~run;
    src.clr      = clr_pulse;
    src.sleep_in = sleep_enter;
    src.fsel_chg = (fsel != fsel_q);
    src.clk_bad  = clk_fail;
    clear        = rst | any_clear(src);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int PRE_DIV = 128,
  parameter int POST_W  = 16,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             timeout
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0]  PRE_TOP  = PRE_W'(PRE_DIV - 1);
  localparam logic [POST_W-1:0] POST_ONE = POST_W'(1);

  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic [POST_W-1:0] post_lim;
  logic              pre_last;

  generate
    if ((1 << PRE_W) == PRE_DIV) begin : g_pow2
      assign pre_last = &pre_cnt;
    end else begin : g_any
      assign pre_last = (pre_cnt == PRE_TOP);
    end
  endgenerate

  // elapsed base periods needed, minus one, for ratio 2^sel
  always_comb post_lim = (POST_ONE << sel) - POST_ONE;

  always_comb timeout = ~clear & tick & pre_last & (post_cnt >= post_lim);

  always_ff @(posedge clk) begin
    if (clear || timeout) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (tick) begin
      if (pre_last) begin
        pre_cnt  <= '0;
        post_cnt <= post_cnt + POST_ONE;
      end else begin
        pre_cnt  <= pre_cnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_req_out.sv
module wdt_req_out (
  input  logic clk,
  input  logic rst,
  input  logic timeout,
  input  logic sleeping,
  output logic rst_req,
  output logic wake_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rst_req  <= timeout & ~sleeping;
      wake_req <= timeout &  sleeping;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int PRE_DIV = 128,
  parameter int POST_W  = 16,
  parameter int SEL_W   = 4,
  parameter int FSEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              cfg_en,
  input  logic              sw_en,
  input  logic [SEL_W-1:0]  post_sel,
  input  logic              clr_pulse,
  input  logic              sleep_enter,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              clk_fail,
  input  logic              sleeping,
  output logic              clk_src_en,
  output logic              rst_req,
  output logic              wake_req
);
  logic run;
  logic clear;
  logic timeout;

  wdt_enable_ctl u_en (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .sw_en(sw_en),
    .run(run), .clk_src_en(clk_src_en)
  );

  wdt_clear_gen #(.FSEL_W(FSEL_W)) u_clr (
    .clk(clk), .rst(rst), .run(run), .clr_pulse(clr_pulse),
    .sleep_enter(sleep_enter), .fsel(fsel), .clk_fail(clk_fail),
    .clear(clear)
  );

  wdt_counter #(.PRE_DIV(PRE_DIV), .POST_W(POST_W), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .clear(clear), .tick(osc_tick), .sel(post_sel),
    .timeout(timeout)
  );

  wdt_req_out u_req (
    .clk(clk), .rst(rst), .timeout(timeout), .sleeping(sleeping),
    .rst_req(rst_req), .wake_req(wake_req)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int FSEL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              sw_en,
  input logic              clr_pulse,
  input logic              sleep_enter,
  input logic [FSEL_W-1:0] fsel,
  input logic              clk_fail,
  input logic              sleeping,
  input logic              clk_src_en,
  input logic              rst_req,
  input logic              wake_req
);
  // R10 / R11: the two requests never coincide
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req));

  // R10: wake only follows a sleeping cycle
  a_r10_wake_asleep: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(sleeping));

  // R11: reset only follows an awake cycle
  a_r11_rst_awake: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(sleeping));

  // R11: requests are single-cycle pulses
  a_r11_rst_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  a_r11_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);

  // R7 / R9: oscillator enable tracks the combined enable
  a_r9_src_on: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> clk_src_en);
  a_r9_src_off: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !sw_en) |=> !clk_src_en);

  // R8: disabled means quiet
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !sw_en) |=> (!rst_req && !wake_req));

  // R4: clear or sleep entry suppresses a timeout in that cycle
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_pulse || sleep_enter) |=> (!rst_req && !wake_req));

  // R5: select change suppresses a timeout in that cycle
  a_r5_fsel: assert property (@(posedge clk) disable iff (rst)
    (fsel != $past(fsel)) |=> (!rst_req && !wake_req));

  // R6: clock failure suppresses a timeout in that cycle
  a_r6_fail: assert property (@(posedge clk) disable iff (rst)
    clk_fail |=> (!rst_req && !wake_req));
endmodule

bind wdt_top wdt_checker #(.FSEL_W(FSEL_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .sw_en(sw_en),
  .clr_pulse(clr_pulse), .sleep_enter(sleep_enter), .fsel(fsel),
  .clk_fail(clk_fail), .sleeping(sleeping), .clk_src_en(clk_src_en),
  .rst_req(rst_req), .wake_req(wake_req)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       cfg_en = 1'b0;
  logic       sw_en = 1'b0;
  logic [3:0] post_sel = '0;
  logic       clr_pulse = 1'b0;
  logic       sleep_enter = 1'b0;
  logic [2:0] fsel = '0;
  logic       clk_fail = 1'b0;
  logic       sleeping = 1'b0;
  logic       clk_src_en, rst_req, wake_req;

  always #5 clk = ~clk;

  wdt_top dut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cfg_en(cfg_en), .sw_en(sw_en),
    .post_sel(post_sel), .clr_pulse(clr_pulse), .sleep_enter(sleep_enter),
    .fsel(fsel), .clk_fail(clk_fail), .sleeping(sleeping),
    .clk_src_en(clk_src_en), .rst_req(rst_req), .wake_req(wake_req)
  );

  int    vectors = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model: one total tick count since the last clear
  int   ticks = 0;
  logic [2:0] fsel_prev = '0;
  logic exp_src = 0, exp_rst = 0, exp_wake = 0;
  int   pulses = 0;

  function automatic bit fires(int n, int s);
    return (n % 128 == 0) && ((n / 128) >= (1 << s));
  endfunction

  task automatic model();
    bit en, clr;
    en  = cfg_en | sw_en;
    clr = ~en | clr_pulse | sleep_enter | clk_fail | (fsel != fsel_prev);
    fsel_prev = fsel;
    exp_rst = 0;
    exp_wake = 0;
    if (rst) begin
      ticks = 0;
      exp_src = 0;
    end else begin
      exp_src = en;
      if (clr) ticks = 0;
      else if (osc_tick) begin
        if (fires(ticks + 1, int'(post_sel))) begin
          ticks = 0;
          exp_rst = ~sleeping;
          exp_wake = sleeping;
        end else ticks = ticks + 1;
      end
    end
  endtask

  task automatic step();
    model();
    @(negedge clk);
    vectors++;
    if (rst_req || wake_req) pulses++;
    if (clk_src_en !== exp_src || rst_req !== exp_rst || wake_req !== exp_wake) begin
      errors++;
      $display("FAIL %s t=%0t src/rst/wake=%b%b%b expected %b%b%b", tag, $time,
               clk_src_en, rst_req, wake_req, exp_src, exp_rst, exp_wake);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_at(int lead, int which, int tail);
    run(lead);
    case (which)
      0: clr_pulse = 1;
      1: sleep_enter = 1;
      2: fsel = fsel + 3'd1;
      default: clk_fail = 1;
    endcase
    step();
    clr_pulse = 0; sleep_enter = 0; clk_fail = 0;
    run(tail);
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    tag = "R1"; rst = 1; cfg_en = 1; osc_tick = 1;
    run(3);
    rst = 0;
    // R2: base period with select 0
    tag = "R2"; pulses = 0; run(260);
    if (pulses != 2) begin
      errors++; $display("FAIL R2 pulses=%0d expected 2", pulses);
    end
    vectors++;
    // R3: select 2 then lowering the select mid-count
    tag = "R3"; rst = 1; step(); rst = 0; post_sel = 2; run(600);
    post_sel = 3; run(700); post_sel = 1; run(300);
    // R4: clear and sleep entry near a boundary
    tag = "R4"; post_sel = 0; rst = 1; step(); rst = 0;
    pulse_at(126, 0, 200); pulse_at(127, 1, 200);
    // R5: frequency select change
    tag = "R5"; rst = 1; step(); rst = 0; pulse_at(127, 2, 200); pulse_at(40, 2, 200);
    // R6: clock failure
    tag = "R6"; rst = 1; step(); rst = 0; pulse_at(127, 3, 200);
    // R7: enable combinations
    tag = "R7"; cfg_en = 0; sw_en = 1; run(300);
    cfg_en = 1; sw_en = 0; run(300);
    // R8: disabled is quiet
    tag = "R8"; cfg_en = 0; sw_en = 0; pulses = 0; run(400);
    if (pulses != 0) begin
      errors++; $display("FAIL R8 pulses=%0d expected 0", pulses);
    end
    vectors++;
    // R9: enable toggling
    tag = "R9";
    for (int i = 0; i < 20; i++) begin
      sw_en = i[0]; cfg_en = i[2]; run(3);
    end
    // R10: timeout while asleep
    tag = "R10"; cfg_en = 1; sleeping = 1; pulses = 0; run(300);
    if (pulses != 2) begin
      errors++; $display("FAIL R10 pulses=%0d expected 2", pulses);
    end
    vectors++;
    // R11: repeated awake timeouts restart the count
    tag = "R11"; sleeping = 0; post_sel = 1; rst = 1; step(); rst = 0;
    pulses = 0; run(1024);
    if (pulses != 4) begin
      errors++; $display("FAIL R11 pulses=%0d expected 4", pulses);
    end
    vectors++;
    // R12: sparse ticks with random disturbances
    tag = "R12";
    for (int i = 0; i < 30000; i++) begin
      osc_tick    = ($urandom % 4) != 0;
      clr_pulse   = ($urandom % 500) == 0;
      sleep_enter = ($urandom % 700) == 0;
      clk_fail    = ($urandom % 900) == 0;
      if (($urandom % 600) == 0) fsel = 3'($urandom);
      if (($urandom % 300) == 0) sleeping = ~sleeping;
      if (($urandom % 800) == 0) post_sel = 4'($urandom % 3);
      if (($urandom % 1500) == 0) begin
        cfg_en = ($urandom % 3) != 0; sw_en = 1'($urandom);
      end
      rst = ($urandom % 4000) == 0;
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule